// File: doc/BRIEF.md
# Multiplexed-Bus Modem Register Interface

This block is the host-facing register port of a modem controller. A host processor shares one 8-bit line set for addresses and data. It first pulses an address strobe, whose falling edge captures a 3-bit register number and the select level. It then uses active-low read or write strobes to move a byte to or from one of four internal registers: two control registers, a tone register and a sticky detect register. Detect events come from logic outside the block as one-cycle flag pulses. They set bits in the detect register and raise an open-drain interrupt, which stays active until the host reads the detect register.

The block also drives a clock output pin. After reset this pin carries the system (crystal) clock. When the host sets a clock-select control bit, and the modulation-mode bit also marks phase-shift keyed operation, the pin instead carries a programmable divided clock that serves as the 16x baud clock. All bus strobes are asynchronous to the system clock. They are synchronized with flop chains and edge-detected in the system clock domain. The tri-state bus and the open-drain interrupt appear as pad-side data, output-enable and pull-low signals.

Top module: `mbus_regif`

## Requirements
- R1: The register number (`ad_i[2:0]`) and the select level (`cs_n`) are captured only at a falling edge of `ale`. Changes of `ad_i` or `cs_n` after that edge do not redirect a following read or write.
- R2: When the captured select is inactive (`cs_n` was high), a write changes no register and `ad_oe` stays 0 through the whole read strobe.
- R3: `ad_oe` is 1 only while `rd_n` is low and the captured select is active. While `ad_oe` is 1, `ad_o` carries the addressed register.
- R4: A write stores `ad_i` at the rising edge of `wr_n` into the addressed register. Address 0 is control A, 1 is control B, 3 is tone. Address 2 (detect) ignores writes.
- R5: Reads of addresses 4 to 7 return 0x00.
- R6: A one-cycle pulse on `det_flags[i]` sets bit i of the detect register (address 2) and sets `irq_oe` to 1 within two clock cycles.
- R7: `irq_oe` stays 1 until a read of address 2 completes at the rising edge of `rd_n`. That read returns the accumulated bits and clears them. Reads of other addresses leave `irq_oe` set.
- R8: `rst` (synchronous, active high) clears control A, control B, tone, detect and `irq_oe`, and returns `clk_out` to the system clock.
- R9: `clk_out` follows `clk` unless control B bit 7 (clock select) and control A bit 0 (phase-shift keyed mode) are both 1.
- R10: In divided mode, `clk_out` changes level every N+1 system clock cycles, where N is control B bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (crystal) clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address strobe; falling edge captures address and select |
| cs_n | input | 1 | Active-low select, captured with the address |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe; data taken at rising edge |
| ad_i | input | 8 | Bus pad input (address, then write data) |
| ad_o | output | 8 | Bus pad output data |
| ad_oe | output | 1 | Bus pad output enable |
| det_flags | input | 8 | One-cycle detect event pulses, one per detect bit |
| irq_oe | output | 1 | Open-drain interrupt pull-low enable (1 = pin pulled low) |
| clk_out | output | 1 | Clock output pin: system clock or divided baud clock |

## Verification
Several kinds of internal fault are visible at the pins. A wrong captured address or select shows up on the first read strobe after the address phase: `ad_o` carries the wrong byte, or `ad_oe` rises when it should stay low, about three clock cycles after `rd_n` falls. A corrupted detect or interrupt state shows up in one of two ways: `irq_oe` drops before the detect read, or `irq_oe` is still high after it. Either is visible within two cycles of the event. A wrong clock selection or divider count changes the spacing of `clk_out` edges, which a short window of sampling exposes within a couple of divided periods.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRLA = 3'd0,
    A_CTRLB = 3'd1,
    A_DET   = 3'd2,
    A_TONE  = 3'd3
  } reg_addr_e;

  // bit positions inside the control registers
  localparam int unsigned PSK_BIT  = 0;  // control A
  localparam int unsigned CSEL_BIT = 7;  // control B
  localparam int unsigned DIV_LSB  = 0;  // control B
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(STAGES); i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbus_decode.sv
module mbus_decode #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ale_s,
  input  logic          cs_n_s,
  input  logic          rd_n_s,
  input  logic          wr_n_s,
  input  logic [DW-1:0] ad_s,
  output logic [AW-1:0] addr_q,
  output logic          sel_q,
  output logic          wr_stb,
  output logic [DW-1:0] wr_data,
  output logic          rd_act,
  output logic          rd_done
);
  logic ale_p, rd_p, wr_p;
  logic ale_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_p <= 1'b0;
      rd_p  <= 1'b1;
      wr_p  <= 1'b1;
    end else begin
      ale_p <= ale_s;
      rd_p  <= rd_n_s;
      wr_p  <= wr_n_s;
    end
  end

  assign ale_fall = ale_p & ~ale_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      sel_q  <= 1'b0;
    end else if (ale_fall) begin
      addr_q <= ad_s[AW-1:0];
      sel_q  <= ~cs_n_s;
    end
  end

  assign wr_stb  = wr_n_s & ~wr_p & sel_q;
  assign wr_data = ad_s;
  assign rd_act  = ~rd_n_s & sel_q;
  assign rd_done = rd_n_s & ~rd_p & sel_q;

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ale_fall |=> $stable(addr_q) && $stable(sel_q));
endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile
  import mbus_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned DIVW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_stb,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic            rd_done,
  input  logic [DW-1:0]   det_in,
  output logic [DW-1:0]   rdata_q,
  output logic            irq_q,
  output logic            psk_en,
  output logic            clk_sel,
  output logic [DIVW-1:0] div_n
);
  logic [DW-1:0] ctrla_q, ctrlb_q, tone_q, det_q;
  logic          det_clr;

  assign det_clr = rd_done && (addr == A_DET);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrla_q <= '0;
      ctrlb_q <= '0;
      tone_q  <= '0;
    end else if (wr_stb) begin
      case (addr)
        A_CTRLA: ctrla_q <= wdata;
        A_CTRLB: ctrlb_q <= wdata;
        A_TONE:  tone_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) det_q <= '0;
    else     det_q <= (det_clr ? '0 : det_q) | det_in;
  end

  always_ff @(posedge clk) begin
    if (rst)          irq_q <= 1'b0;
    else if (|det_in) irq_q <= 1'b1;
    else if (det_clr) irq_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      case (addr)
        A_CTRLA: rdata_q <= ctrla_q;
        A_CTRLB: rdata_q <= ctrlb_q;
        A_DET:   rdata_q <= det_q;
        A_TONE:  rdata_q <= tone_q;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign psk_en  = ctrla_q[PSK_BIT];
  assign clk_sel = ctrlb_q[CSEL_BIT];
  assign div_n   = ctrlb_q[DIV_LSB +: DIVW];

  // R6
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|det_in) |=> irq_q);
  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q && !det_clr |=> irq_q);
  // R2
  no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(ctrla_q) && $stable(ctrlb_q) && $stable(tone_q));
endmodule

// File: rtl/mbus_clkgen.sv
module mbus_clkgen #(
  parameter int unsigned DIVW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            psk_en,
  input  logic            clk_sel,
  input  logic [DIVW-1:0] div_n,
  output logic            clk_out
);
  logic            use_div_q;
  logic [DIVW-1:0] cnt_q;
  logic            div_q;

  always_ff @(posedge clk) begin
    if (rst) use_div_q <= 1'b0;
    else     use_div_q <= psk_en & clk_sel;
  end

  always_ff @(posedge clk) begin
    if (rst || !use_div_q) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (cnt_q >= div_n) begin
      cnt_q <= '0;
      div_q <= ~div_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clk_out = use_div_q ? div_q : clk;

  // R10
  div_steady_chk: assert property (@(posedge clk) disable iff (rst)
    use_div_q && (cnt_q != '0) |-> $stable(div_q));
  // R9
  sel_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !psk_en |=> !use_div_q);
endmodule

// File: rtl/mbus_regif.sv
module mbus_regif
  import mbus_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned DIVW   = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ale,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe,
  input  logic [DW-1:0] det_flags,
  output logic          irq_oe,
  output logic          clk_out
);
  localparam int unsigned AW  = ADDR_W;
  localparam int unsigned SYW = DW + 4;
  localparam logic [SYW-1:0] SY_RST = {1'b0, 1'b1, 1'b1, 1'b1, {DW{1'b0}}};

  logic [SYW-1:0]  pins_s;
  logic            ale_s, cs_n_s, rd_n_s, wr_n_s;
  logic [DW-1:0]   ad_s;
  logic [AW-1:0]   addr_q;
  logic            sel_q, wr_stb, rd_act, rd_done;
  logic [DW-1:0]   wr_data;
  logic            psk_en, clk_sel;
  logic [DIVW-1:0] div_n;
  logic            ad_oe_q;

  mbus_sync #(.W(SYW), .STAGES(STAGES), .RST_VAL(SY_RST)) u_sync (
    .clk(clk), .rst(rst), .d({ale, cs_n, rd_n, wr_n, ad_i}), .q(pins_s)
  );
  assign {ale_s, cs_n_s, rd_n_s, wr_n_s, ad_s} = pins_s;

  mbus_decode #(.DW(DW), .AW(AW)) u_dec (
    .clk(clk), .rst(rst), .ale_s(ale_s), .cs_n_s(cs_n_s), .rd_n_s(rd_n_s),
    .wr_n_s(wr_n_s), .ad_s(ad_s), .addr_q(addr_q), .sel_q(sel_q),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_act(rd_act), .rd_done(rd_done)
  );

  mbus_regfile #(.DW(DW), .AW(AW), .DIVW(DIVW)) u_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .addr(addr_q), .wdata(wr_data),
    .rd_done(rd_done), .det_in(det_flags), .rdata_q(ad_o), .irq_q(irq_oe),
    .psk_en(psk_en), .clk_sel(clk_sel), .div_n(div_n)
  );

  mbus_clkgen #(.DIVW(DIVW)) u_clk (
    .clk(clk), .rst(rst), .psk_en(psk_en), .clk_sel(clk_sel),
    .div_n(div_n), .clk_out(clk_out)
  );

  always_ff @(posedge clk) begin
    if (rst) ad_oe_q <= 1'b0;
    else     ad_oe_q <= rd_act;
  end
  assign ad_oe = ad_oe_q;

  // R2
  no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_q |=> !ad_oe);
  // R3
  drive_rd_chk: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> $past(!rd_n_s));
  // R5
  unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ad_oe && ($past(addr_q) > A_TONE) |-> ad_o == '0);
endmodule

// File: tb/sim_mbus_regif.sv
`timescale 1ns/1ps
module sim_mbus_regif;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] ad_i = 8'h00, det_flags = 8'h00;
  logic [7:0] ad_o;
  logic       ad_oe, irq_oe, clk_out;

  always #2.5 clk = ~clk;

  mbus_regif u0 (
    .clk(clk), .rst(rst), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .det_flags(det_flags),
    .irq_oe(irq_oe), .clk_out(clk_out)
  );

  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t expq[$];
  exp_t e;
  int   total = 0, bad = 0;
  logic oe_prev = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: each new drive of the bus pops one expected byte
  always @(negedge clk) begin
    if (ad_oe && !oe_prev) begin
      if (expq.size() == 0) chk(0, "R2", "unexpected bus drive", ad_o, 0);
      else begin
        e = expq.pop_front();
        chk(ad_o == e.v, e.tag, "read data", ad_o, e.v);
      end
    end
    oe_prev = ad_oe;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic addr_phase(input logic [7:0] a, input logic cs);
    @(negedge clk);
    ad_i = a; cs_n = cs; ale = 1'b1;
    idle(4);
    ale = 1'b0;
    idle(4);
    cs_n = 1'b1; ad_i = 8'h00;
  endtask

  task automatic wr_cycle(input logic [7:0] a, input logic [7:0] d, input logic cs);
    addr_phase(a, cs);
    ad_i = d; wr_n = 1'b0;
    idle(4);
    wr_n = 1'b1;
    idle(4);
    ad_i = 8'h00;
  endtask

  task automatic rd_cycle(input logic [7:0] a, input logic [7:0] v, input string tag);
    exp_t x;
    addr_phase(a, 1'b0);
    x.v = v; x.tag = tag;
    expq.push_back(x);
    rd_n = 1'b0;
    idle(5);
    rd_n = 1'b1;
    idle(5);
  endtask

  task automatic crystal_chk(input string tag);
    repeat (3) begin
      @(posedge clk); #1 chk(clk_out == 1'b1, tag, "clk_out high phase", clk_out, 1);
      @(negedge clk); #1 chk(clk_out == 1'b0, tag, "clk_out low phase", clk_out, 0);
    end
  endtask

  task automatic div_chk(input int n);
    int   last = -1, edges = 0;
    bit   ok = 1'b1;
    logic pv;
    @(negedge clk); pv = clk_out;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (clk_out != pv) begin
        if (last >= 0 && (i - last) != n + 1) ok = 1'b0;
        last = i; edges++;
      end
      pv = clk_out;
    end
    chk(ok && edges >= 3, "R10", "divided clock spacing", edges, n + 1);
  endtask

  task automatic pulse_det(input logic [7:0] f);
    @(negedge clk); det_flags = f;
    @(negedge clk); det_flags = 8'h00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(2);
    // R8 reset state
    chk(ad_oe == 1'b0, "R8", "ad_oe after reset", ad_oe, 0);
    chk(irq_oe == 1'b0, "R8", "irq_oe after reset", irq_oe, 0);
    crystal_chk("R8");

    // R4 write and read back
    wr_cycle(8'd0, 8'h5A, 1'b0);
    wr_cycle(8'd1, 8'h3C, 1'b0);
    wr_cycle(8'd3, 8'hA5, 1'b0);
    rd_cycle(8'd0, 8'h5A, "R4");
    rd_cycle(8'd1, 8'h3C, "R4");
    rd_cycle(8'd3, 8'hA5, "R4");
    // R4 detect address ignores writes
    wr_cycle(8'd2, 8'hFF, 1'b0);
    rd_cycle(8'd2, 8'h00, "R4");
    chk(irq_oe == 1'b0, "R4", "irq after write to detect", irq_oe, 0);

    // R5 unused addresses
    rd_cycle(8'd4, 8'h00, "R5");
    rd_cycle(8'd7, 8'h00, "R5");

    // R2 inactive select: write ignored, bus not driven
    wr_cycle(8'd0, 8'hFF, 1'b1);
    addr_phase(8'd0, 1'b1);
    rd_n = 1'b0;
    idle(3);
    chk(ad_oe == 1'b0, "R2", "bus driven with select off", ad_oe, 0);
    idle(3);
    chk(ad_oe == 1'b0, "R2", "bus driven with select off", ad_oe, 0);
    rd_n = 1'b1;
    idle(5);
    rd_cycle(8'd0, 8'h5A, "R2");

    // R1 address taken at ale fall only; later bus bits do not redirect
    addr_phase(8'd3, 1'b0);
    ad_i = 8'h11; wr_n = 1'b0;
    idle(4);
    wr_n = 1'b1;
    idle(4);
    rd_cycle(8'd1, 8'h3C, "R1");
    rd_cycle(8'd3, 8'h11, "R1");
    // R3 no drive without read strobe
    chk(ad_oe == 1'b0, "R3", "bus idle between reads", ad_oe, 0);

    // R6 detect flags and interrupt
    pulse_det(8'h04);
    idle(2);
    chk(irq_oe == 1'b1, "R6", "irq after flag", irq_oe, 1);
    pulse_det(8'h10);
    idle(20);
    chk(irq_oe == 1'b1, "R7", "irq holds", irq_oe, 1);
    rd_cycle(8'd0, 8'h5A, "R7");
    chk(irq_oe == 1'b1, "R7", "irq after other read", irq_oe, 1);
    rd_cycle(8'd2, 8'h14, "R6");
    chk(irq_oe == 1'b0, "R7", "irq after detect read", irq_oe, 0);
    rd_cycle(8'd2, 8'h00, "R7");

    // R9 select without keyed mode keeps crystal
    wr_cycle(8'd1, 8'h82, 1'b0);
    idle(4);
    crystal_chk("R9");
    wr_cycle(8'd0, 8'h01, 1'b0);
    idle(4);
    div_chk(2);
    wr_cycle(8'd1, 8'h85, 1'b0);
    idle(4);
    div_chk(5);
    wr_cycle(8'd0, 8'h00, 1'b0);
    idle(4);
    crystal_chk("R9");

    // R8 reset mid-run
    wr_cycle(8'd0, 8'h01, 1'b0);
    pulse_det(8'h01);
    idle(4);
    @(negedge clk); rst = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(3);
    chk(irq_oe == 1'b0, "R8", "irq cleared by reset", irq_oe, 0);
    crystal_chk("R8");
    rd_cycle(8'd0, 8'h00, "R8");
    rd_cycle(8'd1, 8'h00, "R8");
    rd_cycle(8'd3, 8'h00, "R8");
    rd_cycle(8'd2, 8'h00, "R8");

    idle(4);
    chk(expq.size() == 0, "R3", "reads left undriven", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule